// File: doc/BRIEF.md
# Coherence Message Flit Segmenter

This block sits in a network interface of a wormhole on-chip network. It accepts one cache-coherence message at a time. A message is either a short control message or a long data message that carries a full cache line. The block builds a 16-bit routing header from the destination, the virtual-channel number, the message class and an opcode. It places that header in front of the payload and cuts the result into flits whose width equals the control payload plus the header.

Control messages fit in one flit. They leave on a dedicated control sub-network port. Data messages become a train of eight flits on a separate data sub-network port. Every flit carries a two-bit position tag beside its data bits, and the unused upper bits of the last data flit are filled with zeros. Each output port has its own valid/ready handshake and its own state, so a stalled data sub-network never holds up control traffic.

Top module: `coh_flit_segmenter`

## Requirements
- R1: A synchronous active-high `rst` forces `ctl_valid` and `dat_valid` low on the next edge and drops any packet that was partly sent. With both paths idle after reset, `msg_ready` is high.
- R2: The header occupies bits [15:0] of a head flit. Bits [7:0] hold the destination, [9:8] the virtual-channel number (four values, so at least three channels can be selected), bit [10] the class (0 control, 1 data) and [15:11] the opcode.
- R3: A control message leaves as exactly one flit on the control port only. Its tag is 2'b11, bits [15:0] hold the header and bits [79:16] hold payload bits [63:0]. Payload bits above 63 are ignored.
- R4: A data message leaves on the data port only, as eight flits tagged 2'b01, then six times 2'b00, then 2'b10. Flit k carries bits [80k+79:80k] of the 640-bit stream formed by the header in bits [15:0] and payload bits [575:0] in bits [591:16].
- R5: Bits [79:32] of the tail data flit are zero.
- R6: While an output's valid is high and its ready is low, that output's valid stays high and its flit and tag stay unchanged on the next cycle.
- R7: `msg_ready` reflects only the path chosen by `msg_is_data`, and it is high only when that path holds no flit. A message offered while its path is busy is not taken and produces no flits.
- R8: A message taken while the other path is stalled is emitted with no delay added by that stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | A message is offered |
| msg_ready | output | 1 | The path of the offered class is idle |
| msg_is_data | input | 1 | 1 for a data message, 0 for a control message |
| msg_dest | input | 8 | Destination node |
| msg_vc | input | 2 | Virtual-channel number |
| msg_op | input | 5 | Opcode |
| msg_payload | input | 576 | Payload; control messages use bits [63:0] |
| ctl_valid | output | 1 | A control flit is presented |
| ctl_ready | input | 1 | The control sub-network takes the flit |
| ctl_flit | output | 80 | Control flit data |
| ctl_tag | output | 2 | Control flit position tag |
| dat_valid | output | 1 | A data flit is presented |
| dat_ready | input | 1 | The data sub-network takes the flit |
| dat_flit | output | 80 | Data flit data |
| dat_tag | output | 2 | Data flit position tag |

## Verification
Directed cases come first. An all-ones data payload shows whether the tail padding is really zero rather than leftover payload. A control payload with set upper bits shows that only the low 64 bits are used. A second data message is offered against a stalled data port to show that it is refused and never emitted. A control message is sent during that stall to separate independent paths from a shared one. A reset in the middle of a train shows that the partial packet is dropped rather than resumed. A seeded random phase then mixes classes, field values and per-cycle backpressure on both ports. Every flit is compared with a stream the bench builds itself, which catches slicing-order, tag and hold errors that the directed cases cannot reach.

// File: rtl/coh_flit_segmenter.sv
`timescale 1ns/1ps
module coh_flit_segmenter #(
  parameter int DEST_W = 8,
  parameter int VC_W   = 2,
  parameter int OP_W   = 5,
  parameter int CTRL_W = 64,
  parameter int DATA_W = 576
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                msg_valid,
  output logic                                msg_ready,
  input  logic                                msg_is_data,
  input  logic [DEST_W-1:0]                   msg_dest,
  input  logic [VC_W-1:0]                     msg_vc,
  input  logic [OP_W-1:0]                     msg_op,
  input  logic [DATA_W-1:0]                   msg_payload,
  output logic                                ctl_valid,
  input  logic                                ctl_ready,
  output logic [OP_W+1+VC_W+DEST_W+CTRL_W-1:0] ctl_flit,
  output logic [1:0]                          ctl_tag,
  output logic                                dat_valid,
  input  logic                                dat_ready,
  output logic [OP_W+1+VC_W+DEST_W+CTRL_W-1:0] dat_flit,
  output logic [1:0]                          dat_tag
);
  localparam int HDR_W      = OP_W + 1 + VC_W + DEST_W;
  localparam int FLIT_W     = HDR_W + CTRL_W;
  localparam int DATA_FLITS = (HDR_W + DATA_W + FLIT_W - 1) / FLIT_W;
  localparam int BUF_W      = DATA_FLITS * FLIT_W;
  localparam int CNT_W      = (DATA_FLITS > 1) ? $clog2(DATA_FLITS) : 1;

  logic [HDR_W-1:0] hdr;
  logic             ctl_take, dat_take, dat_first, dat_last;
  logic [BUF_W-1:0] dat_buf;
  logic [CNT_W-1:0] dat_cnt;

  assign hdr       = {msg_op, msg_is_data, msg_vc, msg_dest};
  assign ctl_take  = msg_valid & ~msg_is_data & ~ctl_valid;
  assign dat_take  = msg_valid &  msg_is_data & ~dat_valid;
  assign msg_ready = msg_is_data ? ~dat_valid : ~ctl_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_valid <= 1'b0;
      ctl_flit  <= '0;
    end else if (ctl_take) begin
      ctl_valid <= 1'b1;
      ctl_flit  <= {msg_payload[CTRL_W-1:0], hdr};
    end else if (ctl_ready) begin
      ctl_valid <= 1'b0;
    end
  end
  assign ctl_tag = 2'b11;

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_valid <= 1'b0;
      dat_buf   <= '0;
      dat_cnt   <= '0;
    end else if (dat_take) begin
      dat_valid <= 1'b1;
      dat_buf   <= BUF_W'({msg_payload, hdr});
      dat_cnt   <= '0;
    end else if (dat_valid && dat_ready) begin
      if (dat_last) begin
        dat_valid <= 1'b0;
      end else begin
        dat_buf <= dat_buf >> FLIT_W;
        dat_cnt <= dat_cnt + 1'b1;
      end
    end
  end

  assign dat_first = (dat_cnt == '0);
  assign dat_last  = (dat_cnt == CNT_W'(DATA_FLITS - 1));
  assign dat_flit  = dat_buf[FLIT_W-1:0];
  assign dat_tag   = {dat_last, dat_first};
endmodule

// File: rtl/coh_flit_segmenter_chk.sv
`timescale 1ns/1ps
module coh_flit_segmenter_chk #(
  parameter int DEST_W = 8,
  parameter int VC_W   = 2,
  parameter int OP_W   = 5,
  parameter int CTRL_W = 64,
  parameter int DATA_W = 576
) (
  input logic                                clk,
  input logic                                rst,
  input logic                                msg_valid,
  input logic                                msg_ready,
  input logic                                msg_is_data,
  input logic [DEST_W-1:0]                   msg_dest,
  input logic [VC_W-1:0]                     msg_vc,
  input logic [OP_W-1:0]                     msg_op,
  input logic [DATA_W-1:0]                   msg_payload,
  input logic                                ctl_valid,
  input logic                                ctl_ready,
  input logic [OP_W+1+VC_W+DEST_W+CTRL_W-1:0] ctl_flit,
  input logic [1:0]                          ctl_tag,
  input logic                                dat_valid,
  input logic                                dat_ready,
  input logic [OP_W+1+VC_W+DEST_W+CTRL_W-1:0] dat_flit,
  input logic [1:0]                          dat_tag
);
  localparam int HDR_W  = OP_W + 1 + VC_W + DEST_W;
  localparam int FLIT_W = HDR_W + CTRL_W;
  localparam int NFL    = (HDR_W + DATA_W + FLIT_W - 1) / FLIT_W;
  localparam int USED_T = HDR_W + DATA_W - (NFL - 1) * FLIT_W;
  localparam int CLS_B  = DEST_W + VC_W;

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!ctl_valid && !dat_valid));

  a_r2_ctl_class_bit: assert property (@(posedge clk) disable iff (rst)
    ctl_valid |-> !ctl_flit[CLS_B]);

  a_r2_dat_class_bit: assert property (@(posedge clk) disable iff (rst)
    (dat_valid && dat_tag == 2'b01) |-> dat_flit[CLS_B]);

  a_r3_ctl_single: assert property (@(posedge clk) disable iff (rst)
    ctl_valid |-> ctl_tag == 2'b11);

  a_r4_dat_head_first: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_ready && msg_is_data) |=> (dat_valid && dat_tag == 2'b01));

  a_r4_dat_end: assert property (@(posedge clk) disable iff (rst)
    (dat_valid && dat_ready && dat_tag == 2'b10) |=> !dat_valid);

  a_r5_tail_pad: assert property (@(posedge clk) disable iff (rst)
    (dat_valid && dat_tag == 2'b10) |-> ((dat_flit >> USED_T) == '0));

  a_r6_ctl_hold: assert property (@(posedge clk) disable iff (rst)
    (ctl_valid && !ctl_ready) |=> (ctl_valid && $stable(ctl_flit) && $stable(ctl_tag)));

  a_r6_dat_hold: assert property (@(posedge clk) disable iff (rst)
    (dat_valid && !dat_ready) |=> (dat_valid && $stable(dat_flit) && $stable(dat_tag)));

  a_r7_busy_refuse: assert property (@(posedge clk) disable iff (rst)
    (msg_is_data ? dat_valid : ctl_valid) |-> !msg_ready);

  a_r8_ctl_free: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_is_data && !ctl_valid) |=> ctl_valid);
endmodule

bind coh_flit_segmenter coh_flit_segmenter_chk #(
  .DEST_W(DEST_W), .VC_W(VC_W), .OP_W(OP_W), .CTRL_W(CTRL_W), .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/coh_flit_segmenter_tb_top.sv
`timescale 1ns/100ps
module coh_flit_segmenter_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         msg_valid = 1'b0;
  logic         msg_ready;
  logic         msg_is_data = 1'b0;
  logic [7:0]   msg_dest = '0;
  logic [1:0]   msg_vc = '0;
  logic [4:0]   msg_op = '0;
  logic [575:0] msg_payload = '0;
  logic         ctl_valid, dat_valid;
  logic         ctl_ready = 1'b1, dat_ready = 1'b1;
  logic [79:0]  ctl_flit, dat_flit;
  logic [1:0]   ctl_tag, dat_tag;

  int n_chk = 0, n_fail = 0;
  int bp = 0;
  logic [81:0] ctl_q[$];
  logic [81:0] dat_q[$];
  logic        ctl_hold = 1'b0, dat_hold = 1'b0;
  logic [81:0] ctl_prev, dat_prev;

  coh_flit_segmenter dut_i (.*);

  initial forever #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [81:0] act, input logic [81:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [639:0] stream(input logic [575:0] pl, input logic d,
      input logic [7:0] dst, input logic [1:0] vc, input logic [4:0] op);
    logic [15:0] h;
    h = {op, d, vc, dst};
    if (d) return 640'({pl, h});
    return 640'({pl[63:0], h});
  endfunction

  always @(posedge clk) begin
    #0.2;
    case (bp)
      0: begin ctl_ready = 1'b1; dat_ready = 1'b1; end
      1: begin ctl_ready = 1'b0; dat_ready = 1'b0; end
      2: begin ctl_ready = ($urandom % 4) != 0; dat_ready = ($urandom % 3) != 0; end
      default: begin ctl_ready = 1'b1; dat_ready = 1'b0; end
    endcase
  end

  always @(negedge clk) begin
    if (rst) begin
      ctl_hold = 1'b0;
      dat_hold = 1'b0;
    end else begin
      if (ctl_hold) chk(ctl_valid && {ctl_tag, ctl_flit} == ctl_prev, "R6 ctl hold", {ctl_tag, ctl_flit}, ctl_prev);
      if (dat_hold) chk(dat_valid && {dat_tag, dat_flit} == dat_prev, "R6 dat hold", {dat_tag, dat_flit}, dat_prev);
      if (ctl_valid && ctl_ready) begin
        if (ctl_q.size() == 0) chk(1'b0, "R3 unexpected ctl flit", {ctl_tag, ctl_flit}, '0);
        else begin
          logic [81:0] e;
          e = ctl_q.pop_front();
          chk({ctl_tag, ctl_flit} == e, "R3 R2 ctl flit", {ctl_tag, ctl_flit}, e);
        end
      end
      if (dat_valid && dat_ready) begin
        if (dat_q.size() == 0) chk(1'b0, "R4 unexpected dat flit", {dat_tag, dat_flit}, '0);
        else begin
          logic [81:0] e;
          e = dat_q.pop_front();
          chk({dat_tag, dat_flit} == e, "R4 R5 R2 dat flit", {dat_tag, dat_flit}, e);
        end
      end
      ctl_hold = ctl_valid && !ctl_ready;
      ctl_prev = {ctl_tag, ctl_flit};
      dat_hold = dat_valid && !dat_ready;
      dat_prev = {dat_tag, dat_flit};
    end
  end

  task automatic send(input logic d, input logic [575:0] pl, input logic [7:0] dst,
      input logic [1:0] vc, input logic [4:0] op);
    logic [639:0] s;
    msg_valid = 1'b1; msg_is_data = d; msg_payload = pl;
    msg_dest = dst; msg_vc = vc; msg_op = op;
    #0.2;
    while (!msg_ready) begin @(posedge clk); #0.4; end
    s = stream(pl, d, dst, vc, op);
    if (d) begin
      for (int k = 0; k < 8; k++)
        dat_q.push_back({(k == 7), (k == 0), s[80*k +: 80]});
    end else begin
      ctl_q.push_back({2'b11, s[79:0]});
    end
    @(posedge clk); #0.4;
    msg_valid = 1'b0;
  endtask

  task automatic drain();
    bp = 0;
    for (int i = 0; i < 3000; i++) begin
      if (ctl_q.size() == 0 && dat_q.size() == 0 && !ctl_valid && !dat_valid) break;
      @(posedge clk); #0.4;
    end
    chk(ctl_q.size() == 0 && dat_q.size() == 0, "R4 all flits delivered",
        82'(ctl_q.size() + dat_q.size()), '0);
  endtask

  function automatic logic [575:0] rnd_payload();
    logic [575:0] p;
    for (int i = 0; i < 18; i++) p[32*i +: 32] = $urandom;
    return p;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #0.4;
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!ctl_valid && !dat_valid && msg_ready, "R1 idle after reset",
        82'({ctl_valid, dat_valid, msg_ready}), 82'(3'b001));
    @(posedge clk); #0.4;

    // R3: upper payload bits set, must be ignored
    send(1'b0, {512'hFFFF, 64'h0123_4567_89AB_CDEF}, 8'h3C, 2'd2, 5'h11);
    // R5: all-ones data payload
    send(1'b1, '1, 8'hFF, 2'd3, 5'h1F);
    drain();

    // R7 and R8: stalled data path
    bp = 3;
    @(posedge clk); #0.4;
    send(1'b1, rnd_payload(), 8'h12, 2'd1, 5'h05);
    msg_valid = 1'b1; msg_is_data = 1'b1; msg_payload = '1;
    for (int i = 0; i < 3; i++) begin
      #0.2;
      chk(!msg_ready, "R7 busy data path refuses", 82'(msg_ready), 82'(0));
      @(posedge clk); #0.2;
    end
    msg_valid = 1'b0;
    @(posedge clk); #0.4;
    send(1'b0, rnd_payload(), 8'h77, 2'd0, 5'h02);
    repeat (3) @(posedge clk);
    #0.4;
    chk(ctl_q.size() == 0 && !ctl_valid && dat_valid, "R8 control passes stalled data",
        82'({ctl_q.size() == 0, ctl_valid, dat_valid}), 82'(3'b101));
    drain();
    chk(!dat_valid, "R7 refused message produced no flits", 82'(dat_valid), 82'(0));

    // R1: reset mid-packet
    bp = 3;
    @(posedge clk); #0.4;
    send(1'b1, rnd_payload(), 8'h01, 2'd2, 5'h0A);
    repeat (2) @(posedge clk);
    #0.4;
    rst = 1'b1;
    @(posedge clk); #0.4;
    rst = 1'b0;
    dat_q.delete();
    ctl_q.delete();
    @(negedge clk);
    chk(!dat_valid && !ctl_valid, "R1 reset drops partial packet",
        82'({dat_valid, ctl_valid}), '0);
    @(posedge clk); #0.4;
    send(1'b1, rnd_payload(), 8'hA0, 2'd1, 5'h13);
    drain();

    // random phase
    bp = 2;
    for (int m = 0; m < 80; m++) begin
      send(1'($urandom), rnd_payload(), 8'($urandom), 2'($urandom), 5'($urandom));
      if (($urandom % 3) == 0) begin @(posedge clk); #0.4; end
    end
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule